// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side master that sends 12-bit conversion codes to a serial voltage-output DAC. Codes arrive on a valid/ready handshake. For each accepted code the block drives one chip-select-low frame of exactly sixteen serial clocks in mode 0: the clock rests low, data moves while it is low, and the DAC samples each bit on the rising edge. Every frame carries four zero fill bits followed by the code, most significant bit first. Chip select rises right after the last bit, which commits the code inside the DAC.

Pacing between frames is the block's other task. The half-period of the serial clock comes from a divider parameter. The block never lets it go below the value that keeps the serial clock at or under the converter's maximum rate. After each frame, chip select stays high for at least a minimum time. When the settle input is high, the next code is also held off for the converter's full-scale settling time, 25 µs by default, which caps large steps at about 40 kHz. With settle low, small steps can run at the full frame rate.

Top module: `dac_frame_writer`

## Requirements
- R1: Each chip-select-low period holds exactly 16 rising edges of `dac_sclk`. The bits sampled on those edges are four zeros followed by the accepted code, most significant bit first.
- R2: `dac_sclk` is low whenever `dac_cs_n` is high, and `dac_sdo` holds steady through every high phase of `dac_sclk`.
- R3: Each low and each high phase of `dac_sclk` lasts DIV_EFF system cycles, where DIV_EFF = max(DIV_HALF, ceil(SYS_FREQ_HZ / (2·SCLK_MAX_HZ))).
- R4: `dac_cs_n` rises on the same cycle that `dac_sclk` falls after the 16th high phase. `frame_done` is high on exactly that first cycle of chip select high and on no other cycle.
- R5: `code_ready` is low while `dac_cs_n` is low. Between frames `dac_cs_n` stays high for at least CSH_CYC cycles. If a code is already waiting, it stays high for exactly that many cycles, and chip select falls on the cycle after the accepting edge.
- R6: If `settle_en` is high, the chip-select-high gap lasts at least SETTLE_CYC = (SYS_FREQ_HZ/1e6)·SETTLE_US cycles, and exactly that many when a code is waiting. If `settle_en` is low, only CSH_CYC applies.
- R7: While reset is held and after it is released, `dac_cs_n` is 1 and `dac_sclk`, `dac_sdo` and `frame_done` are 0. `code_ready` is 1 before the first code arrives.
- R8: `dac_sdo` is 0 on every cycle when `dac_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | A code is offered |
| code_ready | output | 1 | The block can take a code this cycle |
| code_data | input | CODE_W | Code to convert |
| settle_en | input | 1 | 1: apply the settle hold-off; 0: bypass it |
| dac_cs_n | output | 1 | Chip select to the DAC, active low |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data to the DAC |
| frame_done | output | 1 | One-cycle pulse when chip select rises |

## Verification
A wrong shift register or bit counter shows up within one frame, as a wrong word or a bit count other than 16 at the next rise of chip select. A wrong divider count changes the length of the very first serial-clock phase, so a length check on every phase catches it within a few system cycles. Pacer faults only show up between frames. Back-to-back codes with the settle input both high and low make the chip-select-high gap equal its exact expected value, so an early or late release is seen at the next fall of chip select.

// File: rtl/dfw_pkg.sv
package dfw_pkg;

  typedef enum logic [1:0] {
    FW_IDLE = 2'd0,
    FW_LOW  = 2'd1,
    FW_HIGH = 2'd2
  } fw_state_e;

  function automatic int unsigned fw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned fw_ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

endpackage

// File: rtl/dfw_halfper.sv
module dfw_halfper #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF - 1));
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_HALF_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) || run); // R3
endmodule

// File: rtl/dfw_shreg.sv
module dfw_shreg #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned FILL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              sdo,
  output logic              last
);
  localparam int unsigned WORD_W = CODE_W + FILL_W;
  localparam int unsigned BW     = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [BW-1:0]     bit_q, bit_d;

  always_comb begin
    sr_d  = sr_q;
    bit_d = bit_q;
    if (clear) begin
      sr_d  = '0;
      bit_d = '0;
    end else if (load) begin
      sr_d  = {{FILL_W{1'b0}}, code};
      bit_d = '0;
    end else if (shift) begin
      sr_d  = {sr_q[WORD_W-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
    end
  end

  assign sdo  = sr_q[WORD_W-1];
  assign last = (bit_q == BW'(WORD_W - 1));

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (bit_q < BW'(WORD_W - 1))); // R1
endmodule

// File: rtl/dfw_pacer.sv
module dfw_pacer #(
  parameter int unsigned CSH_CYC    = 2,
  parameter int unsigned SETTLE_CYC = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic settle_en,
  output logic open
);
  localparam int unsigned HW = $clog2(CSH_CYC + 1);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic [SW-1:0] sett_q, sett_d;

  always_comb begin
    hold_d = hold_q;
    sett_d = sett_q;
    if (start) begin
      hold_d = HW'(CSH_CYC - 1);
      sett_d = SW'(SETTLE_CYC - 1);
    end else begin
      if (hold_q != '0) hold_d = hold_q - 1'b1;
      if (sett_q != '0) sett_d = sett_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sett_q <= '0;
    end else begin
      hold_q <= hold_d;
      sett_q <= sett_d;
    end
  end

  assign open = (hold_q == '0) && (!settle_en || (sett_q == '0));

  AST_HOLD_DECREASES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) && !start |=> (hold_q == $past(hold_q) - 1'b1)); // R5
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import dfw_pkg::*;
#(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned FILL_W      = 4,
  parameter int unsigned SYS_FREQ_HZ = 250_000_000,
  parameter int unsigned SCLK_MAX_HZ = 14_000_000,
  parameter int unsigned DIV_HALF    = 1,
  parameter int unsigned CSH_CYC     = 2,
  parameter int unsigned SETTLE_US   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  input  logic              settle_en,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              frame_done
);
  localparam int unsigned MIN_DIV    = fw_ceil_div(SYS_FREQ_HZ, 2 * SCLK_MAX_HZ);
  localparam int unsigned DIV_EFF    = fw_max(fw_max(DIV_HALF, MIN_DIV), 1);
  localparam int unsigned SETTLE_CYC = fw_max((SYS_FREQ_HZ / 1_000_000) * SETTLE_US, 1);
  localparam int unsigned CSH_EFF    = fw_max(CSH_CYC, 1);

  fw_state_e st_q, st_d;
  logic      cs_n_q, cs_n_d;
  logic      sclk_q, sclk_d;
  logic      done_q, done_d;
  logic      tick, last, pace_open;
  logic      accept, sr_load, sr_shift, sr_clear;

  dfw_halfper #(.HALF(DIV_EFF)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q != FW_IDLE),
    .tick (tick)
  );

  dfw_shreg #(.CODE_W(CODE_W), .FILL_W(FILL_W)) u_sr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sr_load),
    .shift(sr_shift),
    .clear(sr_clear),
    .code (code_data),
    .sdo  (dac_sdo),
    .last (last)
  );

  dfw_pacer #(.CSH_CYC(CSH_EFF), .SETTLE_CYC(SETTLE_CYC)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (done_d),
    .settle_en(settle_en),
    .open     (pace_open)
  );

  assign code_ready = (st_q == FW_IDLE) && pace_open;
  assign accept     = code_valid && code_ready;

  always_comb begin
    st_d     = st_q;
    cs_n_d   = cs_n_q;
    sclk_d   = sclk_q;
    done_d   = 1'b0;
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    sr_clear = 1'b0;
    unique case (st_q)
      FW_IDLE: begin
        if (accept) begin
          st_d    = FW_LOW;
          cs_n_d  = 1'b0;
          sr_load = 1'b1;
        end
      end
      FW_LOW: begin
        if (tick) begin
          st_d   = FW_HIGH;
          sclk_d = 1'b1;
        end
      end
      FW_HIGH: begin
        if (tick) begin
          sclk_d = 1'b0;
          if (last) begin
            st_d     = FW_IDLE;
            cs_n_d   = 1'b1;
            done_d   = 1'b1;
            sr_clear = 1'b1;
          end else begin
            st_d     = FW_LOW;
            sr_shift = 1'b1;
          end
        end
      end
      default: begin
        st_d   = FW_IDLE;
        cs_n_d = 1'b1;
        sclk_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FW_IDLE;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= cs_n_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign dac_cs_n   = cs_n_q;
  assign dac_sclk   = sclk_q;
  assign frame_done = done_q;

  AST_READY_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> !code_ready); // R5
  AST_DONE_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $rose(dac_cs_n)); // R4
  AST_CS_RISE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> frame_done); // R4
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !dac_sclk); // R2
  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo)); // R2
  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !dac_sdo); // R8
  AST_CS_FALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dac_cs_n && !dac_sclk); // R5
endmodule

// File: tb/test_dac_frame_writer.sv
module test_dac_frame_writer;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned SYS_HZ  = 50_000_000;
  localparam int unsigned DIV_EXP = 2;   // max(1, ceil(50e6 / 28e6))
  localparam int unsigned CSH     = 3;
  localparam int unsigned SET_US  = 4;
  localparam int unsigned SET_EXP = 200; // 50 * 4

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_valid = 1'b0;
  logic [CODE_W-1:0] code_data = '0;
  logic settle_en = 1'b0;
  logic code_ready, dac_cs_n, dac_sclk, dac_sdo, frame_done;

  always #2ns clk = ~clk;

  dac_frame_writer #(
    .CODE_W(CODE_W), .FILL_W(4), .SYS_FREQ_HZ(SYS_HZ), .SCLK_MAX_HZ(14_000_000),
    .DIV_HALF(1), .CSH_CYC(CSH), .SETTLE_US(SET_US)
  ) i_dac_frame_writer (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
    .code_data(code_data), .settle_en(settle_en), .dac_cs_n(dac_cs_n),
    .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .frame_done(frame_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [CODE_W-1:0] q_code[$];
  bit q_se[$];
  bit q_exact[$];

  function automatic logic [15:0] exp_word(input logic [CODE_W-1:0] c);
    return {4'b0000, c};
  endfunction

  function automatic int exp_gap(input bit se);
    return se ? SET_EXP : CSH;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor
  bit mon_on = 1'b0;
  bit have_prev = 1'b0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;
  int run_len = 0, bits = 0, gap = 0;
  logic [15:0] word = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_cs && !dac_cs_n) begin
        if (have_prev && q_se.size() > 0) begin
          if (q_exact[0]) chk(gap == exp_gap(q_se[0]), "R5/R6 exact gap", gap, exp_gap(q_se[0]));
          else            chk(gap >= exp_gap(q_se[0]), "R5/R6 min gap", gap, exp_gap(q_se[0]));
        end
        if (q_se.size() > 0) begin
          void'(q_se.pop_front());
          void'(q_exact.pop_front());
        end
        chk(!dac_sclk, "R2 sclk low at frame start", dac_sclk, 0);
        chk(!code_ready, "R5 ready low in frame", code_ready, 0);
        bits = 0; word = '0; run_len = 1;
      end else if (!dac_cs_n) begin
        chk(!code_ready, "R5 ready low in frame", code_ready, 0);
        chk(!frame_done, "R4 no done in frame", frame_done, 0);
        if (dac_sclk != p_sclk) begin
          chk(run_len == DIV_EXP, "R3 phase length", run_len, DIV_EXP);
          run_len = 1;
          if (dac_sclk) begin
            word = {word[14:0], dac_sdo};
            bits++;
          end
        end else begin
          run_len++;
          if (dac_sclk) chk(dac_sdo == p_sdo, "R2 sdo stable in high phase", dac_sdo, p_sdo);
        end
      end else if (!p_cs && dac_cs_n) begin
        chk(frame_done, "R4 done at cs rise", frame_done, 1);
        chk(!dac_sclk && p_sclk, "R4 sclk falls with cs", dac_sclk, 0);
        chk(run_len == DIV_EXP, "R3 last high phase", run_len, DIV_EXP);
        chk(bits == 16, "R1 rising edges per frame", bits, 16);
        if (q_code.size() > 0) begin
          chk(word == exp_word(q_code[0]), "R1 frame word", word, exp_word(q_code[0]));
          void'(q_code.pop_front());
        end
        chk(!dac_sdo, "R8 sdo low after frame", dac_sdo, 0);
        have_prev = 1'b1;
        gap = 1;
      end else begin
        gap++;
        chk(!dac_sclk, "R2 sclk idle low", dac_sclk, 0);
        chk(!dac_sdo, "R8 sdo idle low", dac_sdo, 0);
        chk(!frame_done, "R4 done one cycle", frame_done, 0);
      end
      p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdo = dac_sdo;
    end
  end

  task automatic send(input logic [CODE_W-1:0] c, input bit se, input int dly);
    if (dly > 0) repeat (dly) @(posedge clk);
    #1;
    code_data = c;
    settle_en = se;
    code_valid = 1'b1;
    do @(negedge clk); while (!code_ready);
    q_code.push_back(c);
    q_se.push_back(se);
    q_exact.push_back(dly == 0);
    @(posedge clk);
    #1;
    code_valid = 1'b0;
    code_data = $urandom;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(dac_cs_n && !dac_sclk && !dac_sdo && !frame_done, "R7 state in reset",
        {dac_cs_n, dac_sclk, dac_sdo, frame_done}, 4'b1000);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac_cs_n && !dac_sclk && !dac_sdo && !frame_done, "R7 state after reset",
        {dac_cs_n, dac_sclk, dac_sdo, frame_done}, 4'b1000);
    chk(code_ready, "R7 ready after reset", code_ready, 1);
    mon_on = 1'b1;
    // directed corners
    send(12'hFFF, 1'b1, 0);
    send(12'h000, 1'b1, 0);  // full-scale step with settle: exact SETTLE gap
    send(12'h555, 1'b0, 0);  // settle bypassed: exact CSH gap
    send(12'hAAA, 1'b0, 0);
    send(12'h801, 1'b1, 300);
    send(12'h001, 1'b0, 0);
    // constrained random
    for (int i = 0; i < 24; i++) begin
      send(CODE_W'($urandom), 1'($urandom % 2), ($urandom % 3 == 0) ? 100 + int'($urandom % 300) : 0);
    end
    repeat (400) @(posedge clk);
    chk(q_code.size() == 0, "R1 every code framed", q_code.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #600us;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule